// File: doc/BRIEF.md
# Read Completion Header Generator

This block turns one decoded read request into the ordered series of completion headers that answer it. A request carries the DW address inside its 4 KB page, the length in DWs, the first and last byte enables, the tag, the requester ID, the traffic class, the attributes, the request kind (memory, I/O or configuration), a completion status chosen by the decoder, and the maximum payload size currently in force. The block then presents one header per cycle on a valid/ready output until the last one has been taken.

Memory reads that succeed are cut into several completions when needed. Each completion stops at an address aligned to the maximum payload size, or at the end of the request. Because that size is never below 128 bytes, every completion after the first begins on a 128-byte completion boundary. The byte count and lower address fields are derived from the byte enables and the alignment. I/O and configuration reads, and any request whose status is not success, are answered with exactly one header. The completer ID is made from the bus and device numbers that the block records from every type 0 configuration write, plus a fixed function number.

Top module: `rdcpl_hdr_gen`

## Requirements
- R1: After reset `cpl_valid` is 0, `req_ready` is 1 and the completer ID on `cpl_cid` carries bus 0 and device 0.
- R2: Every header copies `tc`, `attr`, requester ID and tag from its request. Type is 01010b. Format is 010b (3 DW, with data) for a successful request and 000b (3 DW, no data) otherwise. `cpl_bcm` is always 0.
- R3: `cpl_cid` = {bus[7:0], device[4:0], FUNC_ID[2:0]}, where bus and device are the values sampled on the most recent cycle with `cfg0_wr_valid` high, and zeros before any such cycle.
- R4: For a memory read, the byte count of the first completion is the number of bytes from the lowest set bit of `req_first_be` (bit i enables byte i of the DW) in the first DW to the highest set bit of `req_last_be` in the last DW, inclusive. For a 1-DW request it is the span of `req_first_be` alone, and 1 when that field is 0. 4096 is encoded as 0. Example: DW address 0x20 (byte 0x80), length 33, first enables 1000b, last enables 0111b gives 128.
- R5: For a memory read, the lower address of the first completion is {address bits 6:2, index of the lowest set bit of `req_first_be`}. In the R4 example it is 0x03, so byte 0x83.
- R6: A memory read with `mps_code` = c is split so that each completion ends at a DW address that is a multiple of 32·2^c DWs, or at the end of the request. The payload lengths add up to the request length, and 1024 is encoded 0. Every completion after the first has lower address 0, and its byte count is the previous one minus the bytes the previous one delivered.
- R7: `mps_code` values 0 to 5 select 128 to 4096 bytes (128·2^c). Values 6 and 7 act as 5.
- R8: A successful I/O read (kind 01b) or configuration read (kind 10b) gets one header with length 1, byte count 4 and lower address 0.
- R9: A status other than 000b (unsupported request 001b, configuration retry 010b, completer abort 100b) gives one header with no data: length 0, byte count 4, lower address 0.
- R10: A header stays unchanged while `cpl_valid` is high and `cpl_ready` is low. `req_ready` is low while headers are pending. `cpl_last` marks the final header. `cpl_valid` only rises after a request has been accepted.
- R11: A request length of 0 means 1024 DWs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_dw_addr | input | 10 | DW address inside the 4 KB page (byte address bits 11:2) |
| req_len | input | 10 | Length in DWs, 0 = 1024 |
| req_first_be | input | 4 | Byte enables of the first DW |
| req_last_be | input | 4 | Byte enables of the last DW |
| req_tag | input | 8 | Request tag |
| req_rid | input | 16 | Requester ID |
| req_tc | input | 3 | Traffic class |
| req_attr | input | 2 | Attributes |
| req_kind | input | 2 | 00 memory, 01 I/O, 10 configuration |
| req_status | input | 3 | Completion status to report |
| mps_code | input | 3 | Maximum payload size, 128·2^code bytes |
| cfg0_wr_valid | input | 1 | Type 0 configuration write seen |
| cfg0_bus | input | 8 | Bus number carried by that write |
| cfg0_dev | input | 5 | Device number carried by that write |
| cpl_valid | output | 1 | Header present |
| cpl_ready | input | 1 | Header taken when high together with cpl_valid |
| cpl_fmt | output | 3 | Format field |
| cpl_type | output | 5 | Type field |
| cpl_tc | output | 3 | Traffic class |
| cpl_attr | output | 2 | Attributes |
| cpl_cid | output | 16 | Completer ID |
| cpl_status | output | 3 | Completion status |
| cpl_bcm | output | 1 | Byte count modified, always 0 |
| cpl_byte_count | output | 12 | Bytes still owed, 0 = 4096 |
| cpl_rid | output | 16 | Requester ID |
| cpl_tag | output | 8 | Tag |
| cpl_lower_addr | output | 7 | Lower byte address |
| cpl_length | output | 10 | Payload length in DWs, 0 = 1024 for data |
| cpl_last | output | 1 | Final header of this request |

## Verification
The hardest case to reach is a long split sequence where the first completion is short because it starts just below a payload-aligned boundary, and the later ones are full-sized. A 1024-DW request at the smallest payload size then runs through more than thirty headers while the byte count wraps through the 4096 encoding. The stimulus sweeps every payload code against a set of start offsets (0, 1, 7, 31, 33, 250) and lengths up to 0 (meaning 1024), skipping any combination that would cross the page. It rotates through contiguous byte-enable patterns and withholds `cpl_ready` every third cycle, so headers are also checked while the output is held back.

// File: rtl/rdcpl_pkg.sv
package rdcpl_pkg;
  localparam logic [4:0] CPL_TYPE      = 5'b01010;
  localparam logic [2:0] FMT_3DW_DATA  = 3'b010;
  localparam logic [2:0] FMT_3DW_NODAT = 3'b000;
  localparam logic [2:0] STAT_OK       = 3'b000;

  typedef enum logic [1:0] {
    KIND_MEM = 2'b00,
    KIND_IO  = 2'b01,
    KIND_CFG = 2'b10
  } req_kind_e;

  function automatic logic [1:0] lowest_on(input logic [3:0] be);
    if (be[0])      return 2'd0;
    else if (be[1]) return 2'd1;
    else if (be[2]) return 2'd2;
    else if (be[3]) return 2'd3;
    else            return 2'd0;
  endfunction

  function automatic logic [1:0] highest_on(input logic [3:0] be);
    if (be[3])      return 2'd3;
    else if (be[2]) return 2'd2;
    else if (be[1]) return 2'd1;
    else            return 2'd0;
  endfunction
endpackage

// File: rtl/rdcpl_be_decode.sv
module rdcpl_be_decode
  import rdcpl_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic [LEN_W-1:0] len,
  input  logic [3:0]       first_be,
  input  logic [3:0]       last_be,
  output logic [1:0]       lead_off,
  output logic [LEN_W:0]   dw_total,
  output logic [LEN_W+1:0] byte_total
);
  localparam int BC_W = LEN_W + 2;

  always_comb begin
    lead_off = lowest_on(first_be);
    dw_total = (len == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, len};
    if (dw_total == (LEN_W+1)'(1)) begin
      byte_total = BC_W'(highest_on(first_be)) - BC_W'(lead_off) + BC_W'(1);
    end else begin
      // modular: a full 4 KB transfer lands on the 0 encoding
      byte_total = {len, 2'b00} - BC_W'(lead_off)
                 - BC_W'(2'd3 - highest_on(last_be));
    end
  end
endmodule

// File: rtl/rdcpl_id_capture.sv
module rdcpl_id_capture #(
  parameter int                 BUS_W   = 8,
  parameter int                 DEV_W   = 5,
  parameter int                 FN_W    = 3,
  parameter logic [FN_W-1:0]    FUNC_ID = '0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cap_en,
  input  logic [BUS_W-1:0]             bus_in,
  input  logic [DEV_W-1:0]             dev_in,
  output logic [BUS_W+DEV_W+FN_W-1:0]  cid
);
  logic [BUS_W-1:0] bus_q, bus_d;
  logic [DEV_W-1:0] dev_q, dev_d;

  always_comb begin
    bus_d = bus_q;
    dev_d = dev_q;
    if (cap_en) begin
      bus_d = bus_in;
      dev_d = dev_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q <= '0;
      dev_q <= '0;
    end else begin
      bus_q <= bus_d;
      dev_q <= dev_d;
    end
  end

  assign cid = {bus_q, dev_q, FUNC_ID};

  assert_id_recapture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> cid[BUS_W+DEV_W+FN_W-1:FN_W] == $past({bus_in, dev_in}));
endmodule

// File: rtl/rdcpl_splitter.sv
module rdcpl_splitter #(
  parameter int LEN_W  = 10,
  parameter int RCB_DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             pop,
  input  logic [LEN_W-1:0] cur_in,
  input  logic [LEN_W:0]   rem_in,
  input  logic [LEN_W+1:0] bytes_in,
  input  logic [1:0]       lead_in,
  input  logic [2:0]       code_in,
  output logic             busy,
  output logic [LEN_W-1:0] length,
  output logic [LEN_W+1:0] byte_count,
  output logic [$clog2(RCB_DW)+1:0] lower_addr,
  output logic             is_last
);
  localparam int DW_W     = LEN_W + 1;
  localparam int BC_W     = LEN_W + 2;
  localparam int RCB_LG   = $clog2(RCB_DW);
  localparam int MAX_CODE = LEN_W - RCB_LG;

  logic             busy_q, busy_d, first_q, first_d;
  logic [LEN_W-1:0] cur_q, cur_d;
  logic [DW_W-1:0]  rem_q, rem_d;
  logic [BC_W-1:0]  rb_q, rb_d;
  logic [1:0]       lead_q, lead_d;
  logic [2:0]       code_q, code_d;

  logic [DW_W-1:0]  mps_dw, room, chunk;
  logic [BC_W-1:0]  delivered;

  always_comb begin
    mps_dw    = DW_W'(RCB_DW) << code_q;
    room      = mps_dw - ({1'b0, cur_q} & (mps_dw - DW_W'(1)));
    chunk     = (rem_q < room) ? rem_q : room;
    is_last   = (chunk == rem_q);
    delivered = {chunk[LEN_W-1:0], 2'b00} - (first_q ? BC_W'(lead_q) : '0);
  end

  always_comb begin
    busy_d  = busy_q;
    first_d = first_q;
    cur_d   = cur_q;
    rem_d   = rem_q;
    rb_d    = rb_q;
    lead_d  = lead_q;
    code_d  = code_q;
    if (start) begin
      busy_d  = 1'b1;
      first_d = 1'b1;
      cur_d   = cur_in;
      rem_d   = rem_in;
      rb_d    = bytes_in;
      lead_d  = lead_in;
      code_d  = (int'(code_in) > MAX_CODE) ? 3'(MAX_CODE) : code_in;
    end else if (pop) begin
      if (is_last) begin
        busy_d = 1'b0;
      end else begin
        first_d = 1'b0;
        cur_d   = cur_q + chunk[LEN_W-1:0];
        rem_d   = rem_q - chunk;
        rb_d    = rb_q - delivered;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      first_q <= 1'b0;
      cur_q   <= '0;
      rem_q   <= '0;
      rb_q    <= '0;
      lead_q  <= '0;
      code_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      first_q <= first_d;
      cur_q   <= cur_d;
      rem_q   <= rem_d;
      rb_q    <= rb_d;
      lead_q  <= lead_d;
      code_q  <= code_d;
    end
  end

  assign busy       = busy_q;
  assign length     = chunk[LEN_W-1:0];
  assign byte_count = rb_q;
  assign lower_addr = {cur_q[RCB_LG-1:0], (first_q ? lead_q : 2'b00)};

  assert_hold_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !pop) |=> (busy_q && $stable(length) && $stable(byte_count)
                          && $stable(lower_addr)));

  assert_later_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !is_last) |=> (busy_q && lower_addr == '0));
endmodule

// File: rtl/rdcpl_hdr_gen.sv
module rdcpl_hdr_gen
  import rdcpl_pkg::*;
#(
  parameter int             LEN_W   = 10,
  parameter int             TAG_W   = 8,
  parameter int             BUS_W   = 8,
  parameter int             DEV_W   = 5,
  parameter int             FN_W    = 3,
  parameter logic [FN_W-1:0] FUNC_ID = '0,
  parameter int             RCB_DW  = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [LEN_W-1:0]            req_dw_addr,
  input  logic [LEN_W-1:0]            req_len,
  input  logic [3:0]                  req_first_be,
  input  logic [3:0]                  req_last_be,
  input  logic [TAG_W-1:0]            req_tag,
  input  logic [BUS_W+DEV_W+FN_W-1:0] req_rid,
  input  logic [2:0]                  req_tc,
  input  logic [1:0]                  req_attr,
  input  logic [1:0]                  req_kind,
  input  logic [2:0]                  req_status,
  input  logic [2:0]                  mps_code,
  input  logic                        cfg0_wr_valid,
  input  logic [BUS_W-1:0]            cfg0_bus,
  input  logic [DEV_W-1:0]            cfg0_dev,
  output logic                        cpl_valid,
  input  logic                        cpl_ready,
  output logic [2:0]                  cpl_fmt,
  output logic [4:0]                  cpl_type,
  output logic [2:0]                  cpl_tc,
  output logic [1:0]                  cpl_attr,
  output logic [BUS_W+DEV_W+FN_W-1:0] cpl_cid,
  output logic [2:0]                  cpl_status,
  output logic                        cpl_bcm,
  output logic [LEN_W+1:0]            cpl_byte_count,
  output logic [BUS_W+DEV_W+FN_W-1:0] cpl_rid,
  output logic [TAG_W-1:0]            cpl_tag,
  output logic [$clog2(RCB_DW)+1:0]   cpl_lower_addr,
  output logic [LEN_W-1:0]            cpl_length,
  output logic                        cpl_last
);
  localparam int ID_W = BUS_W + DEV_W + FN_W;

  logic             accept, pop, busy, single, nodata_in;
  logic [1:0]       lead_off;
  logic [LEN_W:0]   dw_total;
  logic [LEN_W+1:0] byte_total;
  logic [LEN_W-1:0] chunk_len;

  logic [2:0]       tc_q, tc_d, st_q, st_d;
  logic [1:0]       attr_q, attr_d;
  logic [ID_W-1:0]  rid_q, rid_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             nodata_q, nodata_d;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign pop       = busy && cpl_ready;
  assign nodata_in = (req_status != STAT_OK);
  assign single    = nodata_in || (req_kind != KIND_MEM);

  rdcpl_be_decode #(.LEN_W(LEN_W)) u_be (
    .len(req_len), .first_be(req_first_be), .last_be(req_last_be),
    .lead_off(lead_off), .dw_total(dw_total), .byte_total(byte_total)
  );

  rdcpl_id_capture #(.BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .FUNC_ID(FUNC_ID)) u_id (
    .clk(clk), .rst_n(rst_n), .cap_en(cfg0_wr_valid),
    .bus_in(cfg0_bus), .dev_in(cfg0_dev), .cid(cpl_cid)
  );

  rdcpl_splitter #(.LEN_W(LEN_W), .RCB_DW(RCB_DW)) u_split (
    .clk(clk), .rst_n(rst_n), .start(accept), .pop(pop),
    .cur_in   (single ? '0 : req_dw_addr),
    .rem_in   (single ? (LEN_W+1)'(1) : dw_total),
    .bytes_in (single ? (LEN_W+2)'(4) : byte_total),
    .lead_in  (single ? 2'b00 : lead_off),
    .code_in  (mps_code),
    .busy(busy), .length(chunk_len), .byte_count(cpl_byte_count),
    .lower_addr(cpl_lower_addr), .is_last(cpl_last)
  );

  always_comb begin
    tc_d     = tc_q;
    st_d     = st_q;
    attr_d   = attr_q;
    rid_d    = rid_q;
    tag_d    = tag_q;
    nodata_d = nodata_q;
    if (accept) begin
      tc_d     = req_tc;
      st_d     = req_status;
      attr_d   = req_attr;
      rid_d    = req_rid;
      tag_d    = req_tag;
      nodata_d = nodata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q     <= '0;
      st_q     <= '0;
      attr_q   <= '0;
      rid_q    <= '0;
      tag_q    <= '0;
      nodata_q <= 1'b0;
    end else begin
      tc_q     <= tc_d;
      st_q     <= st_d;
      attr_q   <= attr_d;
      rid_q    <= rid_d;
      tag_q    <= tag_d;
      nodata_q <= nodata_d;
    end
  end

  assign cpl_valid  = busy;
  assign cpl_fmt    = nodata_q ? FMT_3DW_NODAT : FMT_3DW_DATA;
  assign cpl_type   = CPL_TYPE;
  assign cpl_tc     = tc_q;
  assign cpl_attr   = attr_q;
  assign cpl_status = st_q;
  assign cpl_bcm    = 1'b0;
  assign cpl_rid    = rid_q;
  assign cpl_tag    = tag_q;
  assign cpl_length = nodata_q ? '0 : chunk_len;

  assert_err_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_status != STAT_OK) |-> (cpl_last && cpl_length == '0));

  assert_valid_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpl_valid) |-> $past(req_valid && req_ready));
endmodule

// File: tb/rdcpl_hdr_gen_test.sv
`timescale 1ns/1ps
module rdcpl_hdr_gen_test;
  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic        req_valid, req_ready, cpl_valid, cpl_ready, cpl_bcm, cpl_last;
  logic        cfg0_wr_valid;
  logic [9:0]  req_dw_addr, req_len, cpl_length;
  logic [3:0]  req_first_be, req_last_be;
  logic [7:0]  req_tag, cpl_tag, cfg0_bus;
  logic [15:0] req_rid, cpl_rid, cpl_cid;
  logic [2:0]  req_tc, req_status, mps_code, cpl_fmt, cpl_tc, cpl_status;
  logic [1:0]  req_attr, req_kind, cpl_attr;
  logic [4:0]  cfg0_dev, cpl_type;
  logic [11:0] cpl_byte_count;
  logic [6:0]  cpl_lower_addr;

  rdcpl_hdr_gen uut (.*);

  int total = 0, bad = 0, stall_ctr = 0;
  bit done = 0;
  int exp_cid = 0;
  int e_tc, e_attr, e_rid, e_tag, e_st;
  int h_len, h_bc, h_la, h_last, h_fmt, h_type, h_bcm, h_tc, h_attr, h_rid, h_tag, h_cid, h_st;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_req(input int dw, input int len, input logic [3:0] fb, input logic [3:0] lb,
                          input logic [1:0] kind, input logic [2:0] st, input int code, input int idx);
    @(negedge clk);
    e_tc = idx % 8; e_attr = idx % 4; e_rid = (16'h1000 + idx) & 16'hffff; e_tag = idx % 256; e_st = st;
    req_dw_addr = 10'(dw); req_len = 10'(len); req_first_be = fb; req_last_be = lb;
    req_kind = kind; req_status = st; mps_code = 3'(code);
    req_tc = 3'(e_tc); req_attr = 2'(e_attr); req_rid = 16'(e_rid); req_tag = 8'(e_tag);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic get_hdr();
    forever begin
      @(negedge clk);
      cpl_ready = (stall_ctr % 3) != 1;
      stall_ctr++;
      if (cpl_valid && cpl_ready) begin
        h_len = cpl_length; h_bc = cpl_byte_count; h_la = cpl_lower_addr; h_last = cpl_last;
        h_fmt = cpl_fmt; h_type = cpl_type; h_bcm = cpl_bcm; h_tc = cpl_tc; h_attr = cpl_attr;
        h_rid = cpl_rid; h_tag = cpl_tag; h_cid = cpl_cid; h_st = cpl_status;
        break;
      end
    end
  endtask

  task automatic chk_fields(input bit data);
    chk(h_tc == e_tc && h_attr == e_attr && h_rid == e_rid && h_tag == e_tag && h_st == e_st,
        "R2", "copied fields", {h_tc, h_attr, h_tag}, {e_tc, e_attr, e_tag});
    chk(h_type == 5'b01010 && h_bcm == 0 && h_fmt == (data ? 3'b010 : 3'b000),
        "R2", "fmt/type/bcm", {h_fmt, h_type, h_bcm}, {(data ? 3 : 0), 5'b01010, 1'b0});
    chk(h_cid == exp_cid, "R3", "completer id", h_cid, exp_cid);
  endtask

  function automatic int lo_bit(input logic [3:0] b);
    for (int i = 0; i < 4; i++) if (b[i]) return i;
    return 0;
  endfunction
  function automatic int hi_bit(input logic [3:0] b);
    for (int i = 3; i >= 0; i--) if (b[i]) return i;
    return 0;
  endfunction

  task automatic run_mem(input int dw, input int len, input logic [3:0] fb, input logic [3:0] lb,
                         input int code, input int idx);
    int tot = (len == 0) ? 1024 : len;
    int lo = lo_bit(fb);
    int bytes = (tot == 1) ? hi_bit(fb) - lo + 1 : tot * 4 - lo - (3 - hi_bit(lb));
    int mps = 32 << ((code > 5) ? 5 : code);
    int cur = dw, rem = tot, rb = bytes, sum = 0;
    bit first = 1;
    send_req(dw, len, fb, lb, 2'b00, 3'b000, code, idx);
    while (rem > 0) begin
      int room = mps - (cur % mps);
      int n = (rem < room) ? rem : room;
      get_hdr();
      chk(h_len == n % 1024, "R6", "length", h_len, n % 1024);
      chk(h_bc == rb % 4096, "R4", "byte count", h_bc, rb % 4096);
      chk(h_la == (first ? ((cur * 4) % 128) + lo : 0), "R5", "lower address", h_la,
          first ? ((cur * 4) % 128) + lo : 0);
      chk(h_last == (n == rem), "R10", "last flag", h_last, (n == rem));
      chk_fields(1'b1);
      sum += n;
      rb -= n * 4 - (first ? lo : 0);
      cur += n; rem -= n; first = 0;
    end
    chk(sum == tot, "R11", "length sum", sum, tot);
  endtask

  task automatic run_single(input logic [1:0] kind, input logic [2:0] st, input int idx);
    send_req(idx % 1024, 1, 4'b1111, 4'b0000, kind, st, 2, idx);
    get_hdr();
    chk(h_len == (st == 0 ? 1 : 0), st == 0 ? "R8" : "R9", "length", h_len, st == 0 ? 1 : 0);
    chk(h_bc == 4 && h_la == 0 && h_last == 1, st == 0 ? "R8" : "R9", "bc/la/last",
        {h_bc, h_la, h_last}, {12'd4, 7'd0, 1'b1});
    chk_fields(st == 0);
  endtask

  task automatic cfg_write(input logic [7:0] b, input logic [4:0] d);
    @(negedge clk);
    cfg0_bus = b; cfg0_dev = d; cfg0_wr_valid = 1'b1;
    @(negedge clk);
    cfg0_wr_valid = 1'b0;
    exp_cid = {b, d, 3'b000};
  endtask

  initial begin
    int lens[9] = '{1, 2, 3, 31, 32, 33, 100, 512, 0};
    int offs[6] = '{0, 1, 7, 31, 33, 250};
    logic [3:0] fbs[4] = '{4'b1111, 4'b1110, 4'b1100, 4'b1000};
    logic [3:0] lbs[4] = '{4'b1111, 4'b0111, 4'b0011, 4'b0001};
    logic [3:0] sbs[4] = '{4'b1111, 4'b0110, 4'b1000, 4'b0101};
    int idx = 0;
    rst_n = 1'b0; req_valid = 0; cpl_ready = 0; cfg0_wr_valid = 0;
    cfg0_bus = 0; cfg0_dev = 0; req_dw_addr = 0; req_len = 0; req_first_be = 0; req_last_be = 0;
    req_tag = 0; req_rid = 0; req_tc = 0; req_attr = 0; req_kind = 0; req_status = 0; mps_code = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpl_valid == 0 && req_ready == 1, "R1", "reset handshake", {cpl_valid, req_ready}, 2'b01);
    chk(cpl_cid == 0, "R1", "reset completer id", cpl_cid, 0);
    run_single(2'b10, 3'b000, idx++);            // R8 config read, id still zero (R3)
    cfg_write(8'h5A, 5'h13);
    run_single(2'b01, 3'b000, idx++);            // R8 I/O read
    run_single(2'b00, 3'b001, idx++);            // R9 UR
    run_single(2'b00, 3'b010, idx++);            // R9 CRS
    run_single(2'b10, 3'b100, idx++);            // R9 CA
    run_mem(10'h20, 33, 4'b1000, 4'b0111, 5, idx++);   // R4/R5 worked example
    chk(h_bc == 128 && h_la == 7'h03, "R4", "example bc/la", {h_bc, h_la}, {12'd128, 7'h03});
    run_mem(5, 1, 4'b0000, 4'b0000, 0, idx++);   // R4 zero enables -> 1 byte
    run_mem(3, 1, 4'b0101, 4'b0000, 0, idx++);   // R4 sparse single DW -> 3 bytes
    run_mem(0, 0, 4'b1111, 4'b1111, 7, idx++);   // R7 code 7 acts as 5, R11 1024 DWs
    run_mem(33, 300, 4'b1100, 4'b0011, 6, idx++); // R7 code 6
    cfg_write(8'hC3, 5'h07);
    for (int c = 0; c < 6; c++)
      for (int l = 0; l < 9; l++)
        for (int o = 0; o < 6; o++) begin
          int tot = (lens[l] == 0) ? 1024 : lens[l];
          if (offs[o] + tot <= 1024) begin
            if (tot == 1) run_mem(offs[o], lens[l], sbs[idx % 4], 4'b0000, c, idx);
            else          run_mem(offs[o], lens[l], fbs[idx % 4], lbs[(idx / 4) % 4], c, idx);
            idx++;
          end
        end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R10: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule